// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one 16-bit channel that sits beside a free-running 16-bit up counter. The counter is outside the block and arrives as a value bus and an enable. A single mode input decides what the channel's register does. In capture mode the register records the counter value each time a chosen edge appears on one of two external event inputs. In compare mode the register holds a value written by the CPU, and the channel pulses an interrupt when the counter reaches that value.

Each event input is synchronized by two flops before its edges are detected. Two controls set the trigger: a source select picks the event input, and a two-bit edge code picks rising, falling, both or no edges. The CPU writes the register only in compare mode while the counter is stopped. In every other case the write has no effect. Stopping the counter also suppresses capture triggers, so no capture happens while the counter is held.

Top module: `tmr_capcmp_chan`

## Requirements
- R1: After reset the register reads 0x0000 and both interrupt outputs are low.
- R2: With modeCompare = 0 (capture), a CPU write leaves the register unchanged.
- R3: With modeCompare = 1 (compare), a CPU write updates the register at the next clock edge only while cntEn = 0. While cntEn = 1 the write is ignored.
- R4: While cntEn = 0, edges on the event inputs neither change the register nor raise capIrq.
- R5: srcSel = 0 selects evtIn0 and srcSel = 1 selects evtIn1 as the trigger. Edges on the unselected input have no effect.
- R6: edgeSel encodes the valid edge: 00 = none, 01 = rising, 10 = falling, 11 = both. Edges that the code does not select have no effect.
- R7: A valid capture edge stores the counter value sampled at the third rising clock edge after the input changes. At that same edge capIrq goes high for one cycle. The stored value is held until the next valid edge.
- R8: In compare mode, cmpIrq pulses for one cycle one clock after the counter first takes the register's value. It does not pulse again while the counter stays at that value.
- R9: In compare mode no capture occurs. In capture mode cmpIrq never rises. The two interrupts are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuWrEn | input | 1 | CPU write strobe for the channel register |
| cpuWrData | input | 16 | CPU write data |
| cpuRdData | output | 16 | Current register contents |
| modeCompare | input | 1 | 0 = capture, 1 = compare |
| srcSel | input | 1 | Capture source: 0 = evtIn0, 1 = evtIn1 |
| edgeSel | input | 2 | Valid-edge code (see R6) |
| cntEn | input | 1 | Counter running indication |
| cntValue | input | 16 | Counter value |
| evtIn0 | input | 1 | Asynchronous event input 0 |
| evtIn1 | input | 1 | Asynchronous event input 1 |
| capIrq | output | 1 | One-cycle capture interrupt |
| cmpIrq | output | 1 | One-cycle compare-match interrupt |

## Verification
The hardest case to reach is a compare match that must fire exactly once. The counter has to arrive at the stored value, stay on it for several cycles, then leave and come back. Doing that at the speed of a real counter is not practical from the ports, so the bench drives the counter bus directly. It steps the counter through the match value, then jumps it back onto the value and holds it there, and the scoreboard expects exactly one pulse for each arrival. For capture, the bench holds the counter steady around each event edge so that the expected latched value does not depend on the synchronizer delay. Between events it switches the source, the edge code and the enable, and checks after each change that the edges now deselected leave no trace.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_e;

  typedef struct packed {
    logic loadCpu;
    logic loadCap;
    logic cmpFire;
  } chanStrobe_t;

endpackage

// File: rtl/tcc_ctrl.sv
module tcc_ctrl
  import tcc_pkg::*;
#(
  parameter int NUM_SRC     = 2,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtIn,
  input  logic [SEL_W-1:0]   srcSel,
  input  logic [1:0]         edgeSel,
  input  logic               modeCompare,
  input  logic               cntEn,
  input  logic               cpuWrEn,
  input  logic               cntMatch,
  output chanStrobe_t        strobe
);

  logic [NUM_SRC-1:0] riseVec;
  logic [NUM_SRC-1:0] fallVec;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [SYNC_STAGES:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= '0;
      else       pipe <= {pipe[SYNC_STAGES-1:0], evtIn[i]};
    end
    assign riseVec[i] = pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];
    assign fallVec[i] = ~pipe[SYNC_STAGES-1] & pipe[SYNC_STAGES];
  end

  logic trigHit;
  always_comb begin
    case (edge_e'(edgeSel))
      EDGE_RISE: trigHit = riseVec[srcSel];
      EDGE_FALL: trigHit = fallVec[srcSel];
      EDGE_BOTH: trigHit = riseVec[srcSel] | fallVec[srcSel];
      default:   trigHit = 1'b0;
    endcase
  end

  logic hitNow;
  logic hitPrev;
  assign hitNow = modeCompare & cntMatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hitPrev <= 1'b0;
    else       hitPrev <= hitNow;
  end

  always_comb begin
    strobe.loadCap = ~modeCompare & cntEn & trigHit;
    strobe.loadCpu = modeCompare & ~cntEn & cpuWrEn;
    strobe.cmpFire = hitNow & ~hitPrev;
  end

endmodule

// File: rtl/tcc_datapath.sv
module tcc_datapath
  import tcc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  chanStrobe_t      strobe,
  input  logic [CNT_W-1:0] cpuWrData,
  input  logic [CNT_W-1:0] cntValue,
  output logic [CNT_W-1:0] chanValue,
  output logic             cntMatch,
  output logic             capIrq,
  output logic             cmpIrq
);

  logic [CNT_W-1:0] chanQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanQ  <= '0;
      capIrq <= 1'b0;
      cmpIrq <= 1'b0;
    end else begin
      if (strobe.loadCap)      chanQ <= cntValue;
      else if (strobe.loadCpu) chanQ <= cpuWrData;
      capIrq <= strobe.loadCap;
      cmpIrq <= strobe.cmpFire;
    end
  end

  assign chanValue = chanQ;
  assign cntMatch  = (chanQ == cntValue);

endmodule

// File: rtl/tmr_capcmp_chan.sv
module tmr_capcmp_chan
  import tcc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuWrEn,
  input  logic [CNT_W-1:0] cpuWrData,
  output logic [CNT_W-1:0] cpuRdData,
  input  logic             modeCompare,
  input  logic             srcSel,
  input  logic [1:0]       edgeSel,
  input  logic             cntEn,
  input  logic [CNT_W-1:0] cntValue,
  input  logic             evtIn0,
  input  logic             evtIn1,
  output logic             capIrq,
  output logic             cmpIrq
);

  localparam int NUM_SRC = 2;

  chanStrobe_t strobe;
  logic        cntMatch;

  tcc_ctrl #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(2)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .evtIn       ({evtIn1, evtIn0}),
    .srcSel      (srcSel),
    .edgeSel     (edgeSel),
    .modeCompare (modeCompare),
    .cntEn       (cntEn),
    .cpuWrEn     (cpuWrEn),
    .cntMatch    (cntMatch),
    .strobe      (strobe)
  );

  tcc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cpuWrData (cpuWrData),
    .cntValue  (cntValue),
    .chanValue (cpuRdData),
    .cntMatch  (cntMatch),
    .capIrq    (capIrq),
    .cmpIrq    (cmpIrq)
  );

endmodule

// File: rtl/tcc_chk.sv
module tcc_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             modeCompare,
  input logic             cntEn,
  input logic [CNT_W-1:0] cntValue,
  input logic [CNT_W-1:0] cpuRdData,
  input logic             capIrq,
  input logic             cmpIrq
);

  AST_CAPMODE_WR_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!capIrq && !$past(modeCompare)) |-> $stable(cpuRdData)); // R2

  AST_CMPMODE_WR_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeCompare) && $past(cntEn)) |-> $stable(cpuRdData)); // R3

  AST_CAP_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    capIrq |-> ($past(cntEn) && !$past(modeCompare))); // R4

  AST_CAP_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    capIrq |-> (cpuRdData == $past(cntValue))); // R7

  AST_CMP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    cmpIrq |=> !cmpIrq); // R8

  AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(capIrq && cmpIrq)); // R9

endmodule

bind tmr_capcmp_chan tcc_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tmr_capcmp_chan_bench.sv
`timescale 1ns/1ps
module tmr_capcmp_chan_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuWrEn = 1'b0;
  logic [15:0] cpuWrData = '0;
  logic [15:0] cpuRdData;
  logic        modeCompare = 1'b0;
  logic        srcSel = 1'b0;
  logic [1:0]  edgeSel = 2'b00;
  logic        cntEn = 1'b0;
  logic [15:0] cntValue = '0;
  logic        evtIn0 = 1'b0;
  logic        evtIn1 = 1'b0;
  logic        capIrq;
  logic        cmpIrq;

  always #10 clk = ~clk;

  tmr_capcmp_chan u_tmr_capcmp_chan (.*);

  typedef struct {
    bit          isCmp;
    logic [15:0] val;
    string       req;
  } evItem_t;

  evItem_t expQ[$];
  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expectEv(input bit isCmp, input logic [15:0] val, input string req);
    evItem_t it;
    it.isCmp = isCmp; it.val = val; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpuWrite(input logic [15:0] d);
    cpuWrEn = 1'b1; cpuWrData = d;
    @(negedge clk);
    cpuWrEn = 1'b0;
  endtask

  // monitor: compares interrupt events with the scoreboard queue
  always @(negedge clk) begin
    if (rstN && !done && (capIrq || cmpIrq)) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9 unexpected interrupt", {cmpIrq, capIrq, cpuRdData}, 32'h0);
      end else begin
        evItem_t it;
        it = expQ.pop_front();
        check((cmpIrq == it.isCmp) && (capIrq == !it.isCmp) && (cpuRdData == it.val),
              it.req, {cmpIrq, capIrq, cpuRdData}, {it.isCmp, !it.isCmp, it.val});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    cycles(3);
    check(cpuRdData == 16'h0 && !capIrq && !cmpIrq, "R1 reset state", {capIrq, cmpIrq, cpuRdData}, 0);
    rstN = 1'b1;
    cycles(2);
    check(cpuRdData == 16'h0, "R1 after release", cpuRdData, 0);

    // capture mode, rising edge on source 0
    cntEn = 1'b1; edgeSel = 2'b01; cntValue = 16'h1234;
    cpuWrite(16'hBEEF);
    check(cpuRdData == 16'h0, "R2 write in capture mode", cpuRdData, 0);

    expectEv(0, 16'h1234, "R7 rising capture");
    evtIn0 = 1'b1; cycles(5);
    check(cpuRdData == 16'h1234, "R7 captured value", cpuRdData, 16'h1234);

    cntValue = 16'h2222; evtIn0 = 1'b0; cycles(5);
    check(cpuRdData == 16'h1234, "R6 falling ignored in rise mode", cpuRdData, 16'h1234);

    edgeSel = 2'b10; cntValue = 16'h3333; evtIn0 = 1'b1; cycles(5);
    check(cpuRdData == 16'h1234, "R6 rising ignored in fall mode", cpuRdData, 16'h1234);
    expectEv(0, 16'h3333, "R6 falling capture");
    evtIn0 = 1'b0; cycles(5);
    check(cpuRdData == 16'h3333, "R6 falling captured", cpuRdData, 16'h3333);

    edgeSel = 2'b11; cntValue = 16'h4444;
    expectEv(0, 16'h4444, "R6 both rise");
    evtIn0 = 1'b1; cycles(5);
    check(cpuRdData == 16'h4444, "R6 both mode rise", cpuRdData, 16'h4444);
    cntValue = 16'h5555;
    expectEv(0, 16'h5555, "R6 both fall");
    evtIn0 = 1'b0; cycles(5);
    check(cpuRdData == 16'h5555, "R6 both mode fall", cpuRdData, 16'h5555);

    edgeSel = 2'b00; cntValue = 16'h6666;
    evtIn0 = 1'b1; cycles(5); evtIn0 = 1'b0; cycles(5);
    check(cpuRdData == 16'h5555, "R6 no-edge code", cpuRdData, 16'h5555);

    // source selection
    edgeSel = 2'b11; srcSel = 1'b0;
    evtIn1 = 1'b1; cycles(5); evtIn1 = 1'b0; cycles(5);
    check(cpuRdData == 16'h5555, "R5 unselected input", cpuRdData, 16'h5555);
    srcSel = 1'b1; cntValue = 16'h7777;
    evtIn0 = 1'b1; cycles(5); evtIn0 = 1'b0; cycles(5);
    check(cpuRdData == 16'h5555, "R5 input 0 deselected", cpuRdData, 16'h5555);
    expectEv(0, 16'h7777, "R5 input 1 capture");
    evtIn1 = 1'b1; cycles(5);
    check(cpuRdData == 16'h7777, "R5 selected input 1", cpuRdData, 16'h7777);
    check(expQ.size() == 0, "R7 capIrq delivered", expQ.size(), 0);

    // enable gating
    cntEn = 1'b0; cntValue = 16'h8888;
    evtIn1 = 1'b0; cycles(5); evtIn1 = 1'b1; cycles(5);
    check(cpuRdData == 16'h7777, "R4 capture while stopped", cpuRdData, 16'h7777);

    // compare mode writes
    modeCompare = 1'b1; cntEn = 1'b1; cntValue = 16'h9999;
    cpuWrite(16'h0100);
    check(cpuRdData == 16'h7777, "R3 write while running", cpuRdData, 16'h7777);
    cntEn = 1'b0;
    cpuWrite(16'h0100);
    check(cpuRdData == 16'h0100, "R3 write while stopped", cpuRdData, 16'h0100);

    cntEn = 1'b1;
    evtIn1 = 1'b0; cycles(5);
    check(cpuRdData == 16'h0100, "R9 no capture in compare mode", cpuRdData, 16'h0100);

    // compare match stepping through the value
    expectEv(1, 16'h0100, "R8 first match");
    for (int v = 16'h00F0; v <= 16'h0110; v++) begin
      cntValue = v[15:0];
      @(negedge clk);
    end
    check(expQ.size() == 0, "R8 match pulse seen", expQ.size(), 0);

    expectEv(1, 16'h0100, "R8 return to match");
    cntValue = 16'h0100; cycles(8);
    check(expQ.size() == 0 && cpuRdData == 16'h0100, "R8 single pulse while holding", expQ.size(), 0);

    // capture mode with counter equal to register: no compare pulse
    cntValue = 16'h0200; cycles(2);
    modeCompare = 1'b0; cycles(2);
    cntValue = 16'h0100; cycles(6);
    check(!cmpIrq && cpuRdData == 16'h0100, "R9 no compare in capture mode", cmpIrq, 0);

    cycles(4);
    check(expQ.size() == 0, "R7 R8 all events seen", expQ.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule